// File: doc/BRIEF.md
# Descriptor Table Address Resolver

This block keeps the base and limit of a global descriptor table and of an interrupt gate table, plus a local table selector with a cached copy of the local table's base and limit. Software writes and reads the two 48-bit table registers directly. Writing a selector into the local table register starts an automatic two-word read of the matching entry from the global table. The block then uses that entry as the active local table.

A combinational lookup port takes a 16-bit segment selector, or an 8-bit interrupt vector, and returns the physical byte address of the 8-byte entry it names. When the entry does not fit entirely inside the table, the port raises a limit fault instead of an address. Privilege checks and the decoding of descriptor attributes are done elsewhere. This block resolves addresses and checks limits only.

Top module: `desc_table_resolver`

## Requirements
- R1: After reset both table registers read back as zero, the local cache is invalid, the fetch is idle, and every lookup reports a fault (a zero limit cannot hold an 8-byte entry).
- R2: A pulse on `gtab_ld_i` or `itab_ld_i` captures `tab_wdata_i` into that table register. `gtab_rd_o` and `itab_rd_o` return the last captured value from the next cycle on. Bits 15:0 are the limit (table size minus one) and bits 47:16 are the 32-bit base.
- R3: With `lk_vec_i` low, selector bit 2 picks the table (0 = global, 1 = local). Bits 15:3 are the entry index, bits 1:0 have no effect on the result, and the address is base + index*8.
- R4: A lookup is valid only when index*8+7 is at most the table limit. Otherwise `lk_fault_o` is 1 and `lk_addr_o` is 0.
- R5: With `lk_vec_i` high, `lk_sel_i[7:0]` is a vector into the interrupt table, `lk_sel_i[15:8]` is ignored, and the address is base + vector*8 under the same limit rule.
- R6: Loading a local selector while idle, with its entry inside the global limit, issues two reads: first at global base + index*8, then 4 bytes higher. `mem_req_o` and `lbusy_o` stay high until the second `mem_rvalid_i`, and each read's address holds until its own `mem_rvalid_i`.
- R7: When the fetch completes, the local table base is the first returned word and the local limit is bits 15:0 of the second word, and `lvalid_o` rises.
- R8: A local-table lookup faults whenever the cache is invalid, including during a fetch.
- R9: A local selector whose entry lies past the global limit is stored (`lsel_o` shows it) but issues no read and leaves the cache invalid. Selector bit 2 plays no part in the fetch.
- R10: A local selector load while a fetch is in progress is ignored: `lsel_o` and the fetched entry are unchanged.
- R11: Base plus offset wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gtab_ld_i | input | 1 | Load global table register |
| itab_ld_i | input | 1 | Load interrupt table register |
| tab_wdata_i | input | 48 | Table register write value {base, limit} |
| gtab_rd_o | output | 48 | Global table register contents |
| itab_rd_o | output | 48 | Interrupt table register contents |
| lsel_ld_i | input | 1 | Load local table selector |
| lsel_i | input | 16 | Local table selector value |
| lsel_o | output | 16 | Current local table selector |
| lbusy_o | output | 1 | Local descriptor fetch in progress |
| lvalid_o | output | 1 | Local descriptor cache valid |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid, completes current read |
| mem_rdata_i | input | 32 | Read data word |
| lk_sel_i | input | 16 | Lookup selector, or vector in bits 7:0 |
| lk_vec_i | input | 1 | Lookup is an interrupt vector |
| lk_addr_o | output | 32 | Resolved entry byte address |
| lk_fault_o | output | 1 | Entry lies beyond the limit or table invalid |

## Verification
Lookups are driven with limits of 0, 7, 8, 15, 255 and 65535 and with random values. Indices are placed just below, at and just past the last whole entry, which separates an off-by-one in the index*8+7 comparison from a comparison that uses the start of the entry. Each lookup is applied with both values of the table bit, in vector mode, and with random privilege bits and upper vector bits, which shows whether the global, local or interrupt register is chosen and whether the ignored fields leak in. Local selectors are loaded both inside and outside the global limit, against a memory model with a random response delay, and a second load is applied mid-fetch. This separates a correct read order and word split from a fetch that skips, reorders or restarts.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int ADDR_W  = 32;
  localparam int LIM_W   = 16;
  localparam int SEL_W   = 16;
  localparam int VEC_W   = 8;
  localparam int ENT_LG  = 3;                 // 8-byte entries
  localparam int DATA_W  = 32;
  localparam int TREG_W  = ADDR_W + LIM_W;
  localparam int IDX_W   = SEL_W - ENT_LG;
  localparam int N_TREG  = 2;
  localparam int TI_BIT  = 2;
  localparam int WORD_B  = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } treg_t;

  typedef enum logic [1:0] {FS_IDLE, FS_LO, FS_HI} fetch_st_e;

  function automatic logic [LIM_W-1:0] sel_off(input logic [SEL_W-1:0] sel);
    return {sel[SEL_W-1:ENT_LG], {ENT_LG{1'b0}}};
  endfunction

  function automatic logic [LIM_W-1:0] vec_off(input logic [VEC_W-1:0] vec);
    logic [LIM_W-1:0] o;
    o = '0;
    o[VEC_W+ENT_LG-1:ENT_LG] = vec;
    return o;
  endfunction

  // whole entry (off .. off+7) inside limit
  function automatic logic fits(input logic [LIM_W-1:0] off, input logic [LIM_W-1:0] lim);
    return (off | LIM_W'((1 << ENT_LG) - 1)) <= lim;
  endfunction
endpackage

// File: rtl/dtr_table_reg.sv
module dtr_table_reg #(
  parameter int W = dtr_pkg::TREG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/dtr_ldt_fetch.sv
module dtr_ldt_fetch
  import dtr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  treg_t             gtab_i,
  output logic [SEL_W-1:0]  sel_o,
  output treg_t             ldesc_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i
);
  fetch_st_e st_q;
  logic [LIM_W-1:0] off;
  logic             in_rng;
  logic             unused_hi;

  assign off       = sel_off(sel_i);
  assign in_rng    = fits(off, gtab_i.limit);
  assign unused_hi = ^rdata_i[DATA_W-1:LIM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_IDLE;
      sel_o   <= '0;
      ldesc_o <= '0;
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (ld_i) begin
          sel_o   <= sel_i;
          valid_o <= 1'b0;
          if (in_rng) begin
            addr_o <= gtab_i.base + ADDR_W'(off);
            st_q   <= FS_LO;
          end
        end
        FS_LO: if (rvalid_i) begin
          ldesc_o.base <= rdata_i[ADDR_W-1:0];
          addr_o       <= addr_o + ADDR_W'(WORD_B);
          st_q         <= FS_HI;
        end
        FS_HI: if (rvalid_i) begin
          ldesc_o.limit <= rdata_i[LIM_W-1:0];
          valid_o       <= 1'b1;
          st_q          <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != FS_IDLE);
  assign req_o  = busy_o;
endmodule

// File: rtl/dtr_lookup.sv
module dtr_lookup
  import dtr_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              vec_i,
  input  treg_t             gtab_i,
  input  treg_t             itab_i,
  input  treg_t             ltab_i,
  input  logic              lvalid_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  treg_t            tab;
  logic             tab_ok;
  logic [LIM_W-1:0] off;
  logic             unused_rpl;

  assign unused_rpl = ^sel_i[1:0];

  always_comb begin
    if (vec_i) begin
      tab    = itab_i;
      tab_ok = 1'b1;
      off    = vec_off(sel_i[VEC_W-1:0]);
    end else if (sel_i[TI_BIT]) begin
      tab    = ltab_i;
      tab_ok = lvalid_i;
      off    = sel_off(sel_i);
    end else begin
      tab    = gtab_i;
      tab_ok = 1'b1;
      off    = sel_off(sel_i);
    end
    fault_o = !(tab_ok && fits(off, tab.limit));
    addr_o  = fault_o ? '0 : tab.base + ADDR_W'(off);
  end
endmodule

// File: rtl/desc_table_resolver.sv
module desc_table_resolver
  import dtr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gtab_ld_i,
  input  logic                itab_ld_i,
  input  logic [TREG_W-1:0]   tab_wdata_i,
  output logic [TREG_W-1:0]   gtab_rd_o,
  output logic [TREG_W-1:0]   itab_rd_o,
  input  logic                lsel_ld_i,
  input  logic [SEL_W-1:0]    lsel_i,
  output logic [SEL_W-1:0]    lsel_o,
  output logic                lbusy_o,
  output logic                lvalid_o,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic [SEL_W-1:0]    lk_sel_i,
  input  logic                lk_vec_i,
  output logic [ADDR_W-1:0]   lk_addr_o,
  output logic                lk_fault_o
);
  localparam int GI = 0;
  localparam int II = 1;

  logic [N_TREG-1:0] ld_v;
  treg_t             treg [N_TREG];
  treg_t             ldesc;

  assign ld_v[GI] = gtab_ld_i;
  assign ld_v[II] = itab_ld_i;

  for (genvar g = 0; g < N_TREG; g++) begin : g_treg
    dtr_table_reg #(.W(TREG_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (ld_v[g]),
      .d_i   (tab_wdata_i),
      .q_o   (treg[g])
    );
  end

  assign gtab_rd_o = treg[GI];
  assign itab_rd_o = treg[II];

  dtr_ldt_fetch u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (lsel_ld_i),
    .sel_i   (lsel_i),
    .gtab_i  (treg[GI]),
    .sel_o   (lsel_o),
    .ldesc_o (ldesc),
    .valid_o (lvalid_o),
    .busy_o  (lbusy_o),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .rvalid_i(mem_rvalid_i),
    .rdata_i (mem_rdata_i)
  );

  dtr_lookup u_lookup (
    .sel_i   (lk_sel_i),
    .vec_i   (lk_vec_i),
    .gtab_i  (treg[GI]),
    .itab_i  (treg[II]),
    .ltab_i  (ldesc),
    .lvalid_i(lvalid_o),
    .addr_o  (lk_addr_o),
    .fault_o (lk_fault_o)
  );
endmodule

// File: rtl/dtr_checker.sv
module dtr_checker
  import dtr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gtab_ld_i,
  input logic              itab_ld_i,
  input logic [TREG_W-1:0] tab_wdata_i,
  input logic [TREG_W-1:0] gtab_rd_o,
  input logic [TREG_W-1:0] itab_rd_o,
  input logic              lsel_ld_i,
  input logic [SEL_W-1:0]  lsel_i,
  input logic [SEL_W-1:0]  lsel_o,
  input logic              lbusy_o,
  input logic              lvalid_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [SEL_W-1:0]  lk_sel_i,
  input logic              lk_vec_i,
  input logic [ADDR_W-1:0] lk_addr_o,
  input logic              lk_fault_o
);
  assert_gload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gtab_ld_i |=> gtab_rd_o == $past(tab_wdata_i));

  assert_iload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itab_ld_i |=> itab_rd_o == $past(tab_wdata_i));

  assert_fault_noaddr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_addr_o == '0);

  assert_first_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbusy_o && !$past(lbusy_o)) |->
      mem_addr_o == gtab_rd_o[TREG_W-1:LIM_W] + ADDR_W'({lsel_o[SEL_W-1:ENT_LG], 3'b000}));

  assert_second_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbusy_o && $past(lbusy_o) && $past(mem_rvalid_i)) |-> mem_addr_o == $past(mem_addr_o) + 4);

  assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> $stable(mem_addr_o));

  assert_busy_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbusy_o |-> !lvalid_o);

  assert_invalid_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvalid_o && !lk_vec_i && lk_sel_i[TI_BIT]) |-> lk_fault_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbusy_o && lsel_ld_i) |=> $stable(lsel_o));
endmodule

bind desc_table_resolver dtr_checker u_chk (.*);

// File: tb/desc_table_resolver_bench.sv
`timescale 1ns/1ps
module desc_table_resolver_bench;
  logic        clk = 0, rst_n = 0;
  logic        gtab_ld = 0, itab_ld = 0, lsel_ld = 0, lk_vec = 0;
  logic [47:0] wdata = '0;
  logic [15:0] lsel = '0, lk_sel = '0;
  logic [47:0] gtab_rd, itab_rd;
  logic [15:0] lsel_q;
  logic        lbusy, lvalid, mem_req, lk_fault;
  logic [31:0] mem_addr, lk_addr;
  logic        rvalid = 0;
  logic [31:0] rdata = '0;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // bench model state
  logic [47:0] g_m = '0, i_m = '0;
  logic [31:0] l_base = '0;
  logic [15:0] l_lim = '0;
  logic        l_ok = 0;

  // memory responder
  int          lat = 0, rd_cnt = 0;
  logic [31:0] a_prev = '0, a_last = '0;

  always #10 clk = ~clk;

  desc_table_resolver u_desc_table_resolver (
    .clk_i(clk), .rst_ni(rst_n),
    .gtab_ld_i(gtab_ld), .itab_ld_i(itab_ld), .tab_wdata_i(wdata),
    .gtab_rd_o(gtab_rd), .itab_rd_o(itab_rd),
    .lsel_ld_i(lsel_ld), .lsel_i(lsel), .lsel_o(lsel_q),
    .lbusy_o(lbusy), .lvalid_o(lvalid),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .lk_sel_i(lk_sel), .lk_vec_i(lk_vec), .lk_addr_o(lk_addr), .lk_fault_o(lk_fault)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (mem_req && !rvalid) begin
      if (lat == 0) begin
        rvalid <= 1'b1;
        rdata  <= mem_word(mem_addr);
        a_prev <= a_last;
        a_last <= mem_addr;
        rd_cnt <= rd_cnt + 1;
        lat    <= $urandom % 3;
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_lookup(input logic [15:0] sel, input logic vec);
    logic [15:0] off, lim;
    logic [31:0] base;
    logic        ok;
    if (vec) begin
      off = {5'b0, sel[7:0], 3'b0}; base = i_m[47:16]; lim = i_m[15:0]; ok = 1;
    end else if (sel[2]) begin
      off = {sel[15:3], 3'b0}; base = l_base; lim = l_lim; ok = l_ok;
    end else begin
      off = {sel[15:3], 3'b0}; base = g_m[47:16]; lim = g_m[15:0]; ok = 1;
    end
    if (ok && ({16'b0, off} + 32'd7 <= {16'b0, lim})) return {1'b0, base + {16'b0, off}};
    return {1'b1, 32'b0};
  endfunction

  task automatic lookup(input string req, input logic [15:0] sel, input logic vec);
    @(negedge clk);
    lk_sel = sel; lk_vec = vec;
    #1;
    chk(req, {31'b0, lk_fault, lk_addr}, {31'b0, exp_lookup(sel, vec)});
  endtask

  task automatic load_tab(input bit intr, input logic [47:0] v);
    @(negedge clk);
    wdata = v;
    if (intr) itab_ld = 1; else gtab_ld = 1;
    @(negedge clk);
    gtab_ld = 0; itab_ld = 0;
    if (intr) i_m = v; else g_m = v;
    chk("R2", {16'b0, intr ? itab_rd : gtab_rd}, {16'b0, v});
  endtask

  // load local selector; optional second load mid-fetch (R10)
  task automatic load_lsel(input logic [15:0] sel, input bit poke);
    int          c0, n;
    logic [31:0] ea;
    logic        inr;
    ea  = g_m[47:16] + {16'b0, sel[15:3], 3'b0};
    inr = ({16'b0, sel[15:3], 3'b0} + 32'd7) <= {16'b0, g_m[15:0]};
    @(negedge clk);
    c0 = rd_cnt;
    lsel = sel; lsel_ld = 1;
    @(negedge clk);
    lsel_ld = 0;
    l_ok = 0;
    chk("R9", {48'b0, lsel_q}, {48'b0, sel});
    if (inr) begin
      chk("R6", {62'b0, lbusy, mem_req}, {62'b0, 2'b11});
      chk("R8", {63'b0, lvalid}, 64'd0);
      if (poke) begin
        lsel = ~sel; lsel_ld = 1;
        @(negedge clk);
        lsel_ld = 0;
      end
      n = 0;
      while (lbusy && n < 100) begin @(negedge clk); n++; end
      chk("R6", {32'b0, rd_cnt - c0}, 64'd2);
      chk("R6", {a_prev, a_last}, {ea, ea + 32'd4});
      chk("R10", {48'b0, lsel_q}, {48'b0, sel});
      l_base = mem_word(ea);
      l_lim  = mem_word(ea + 32'd4) ^ 32'h0;
      l_lim  = mem_word(ea + 32'd4);
      l_ok   = 1;
      chk("R7", {63'b0, lvalid}, 64'd1);
    end else begin
      repeat (4) @(negedge clk);
      chk("R9", {32'b0, rd_cnt - c0}, 64'd0);
      chk("R9", {62'b0, lbusy, lvalid}, 64'd0);
    end
  endtask

  function automatic logic [15:0] pick_lim();
    case ($urandom % 7)
      0: return 16'h0000;
      1: return 16'h0007;
      2: return 16'h0008;
      3: return 16'h000F;
      4: return 16'h00FF;
      5: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [15:0] pick_sel(input logic [15:0] lim);
    logic [15:0] s;
    s = 16'($urandom);
    if ($urandom % 2) s[15:3] = 13'(($urandom % ({16'b0, lim} / 8 + 3)));
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {16'b0, gtab_rd}, 64'd0);
    chk("R1", {16'b0, itab_rd}, 64'd0);
    chk("R1", {62'b0, lbusy, lvalid}, 64'd0);
    lookup("R1", 16'h0000, 0);
    lookup("R1", 16'h0004, 0);
    lookup("R1", 16'h0000, 1);

    // R4 boundaries on global table, limit 0x0F holds entries 0 and 1
    load_tab(0, {32'h0010_0000, 16'h000F});
    lookup("R4", 16'h0008, 0);
    lookup("R4", 16'h0010, 0);
    load_tab(0, {32'h0010_0000, 16'h000E});
    lookup("R4", 16'h0008, 0);
    lookup("R4", 16'h0003, 0);   // R3 rpl bits ignored
    // R5 interrupt table example: base 11000h limit 1FFh
    load_tab(1, {32'h0001_1000, 16'h01FF});
    lookup("R5", 16'hAB3F, 1);   // last gate 111F8h
    lookup("R5", 16'h0040, 1);
    lookup("R5", 16'h0000, 1);
    // R8 local invalid
    lookup("R8", 16'h0004, 0);
    // R11 wrap
    load_tab(0, {32'hFFFF_FFF0, 16'hFFFF});
    lookup("R11", 16'h001B, 0);
    // R9 out-of-range local selector
    load_tab(0, {32'h0000_2000, 16'h00FF});
    load_lsel(16'h0100, 0);
    lookup("R8", 16'h0004, 0);
    // R6/R7/R10 fetch with mid-fetch reload
    load_lsel(16'h0018, 1);
    lookup("R3", 16'h0006, 0);
    lookup("R3", 16'h0002, 0);
    load_lsel(16'h0007, 0);  // R9 ti bit plays no part in fetch
    lookup("R7", 16'h0004, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0: load_tab(0, {32'($urandom), pick_lim()});
        1: load_tab(1, {32'($urandom), pick_lim()});
        2: load_lsel(pick_sel(g_m[15:0]), ($urandom % 4) == 0);
        default: begin
          logic [15:0] s;
          logic        v;
          v = ($urandom % 3) == 0;
          s = pick_sel(v ? i_m[15:0] : (s[2] ? l_lim : g_m[15:0]));
          if (v) s[10:3] = 8'($urandom % ({16'b0, i_m[15:0]} / 8 + 3));
          lookup(v ? "R5" : (s[2] ? "R3" : "R4"), v ? {s[15:11], s[2:0], s[10:3]} : s, v);
        end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule